// File: doc/BRIEF.md
# Frame Sync Pulse Generator

This block turns a fast output clock into a low-rate frame sync pulse. A phase counter runs from zero up to a programmable divide ratio minus one and wraps; the output is held at its active level for a programmable number of fast-clock cycles at the start of every frame. The width comes from a 10-bit field, or from a half-ratio (50%) mode, and a polarity bit chooses which logic level counts as active.

The frame phase can be snapped to an external sync reference. Once a realignment is armed, the next rising edge of the reference restarts the frame counter in one step. A realignment is armed at reset, by a realign request pulse, and by a rising edge on the lock indication. Any reference edge that arrives while nothing is armed leaves the phase alone. Instead, it measures how far the reference is from the frame start and raises an alarm when that distance exceeds a programmable power-of-two limit. The ratio register accepts only legal ratios. While a realignment is armed, a write also needs a qualifier input.

Top module: `fsync_gen`

## Requirements
- R1: Reset (synchronous, active-low) puts the output at its inactive level, clears the alarm, loads a divide ratio of 8 and arms a realignment, so the first reference edge after reset aligns the frame with no request.
- R2: Let the aligning event happen at clock edge E. That event is either a reference edge first sampled high at E (low at the edge before) or an accepted ratio write sampled at E. After edge E+m (m >= 1), the output is active exactly when (m-1) mod D < W, where D is the divide ratio and W is the effective width.
- R3: With half mode off, W equals the width field when the field is below D, and D-1 otherwise. With D = 1 the output never becomes active.
- R4: With half mode on, W = floor(D/2) and the width field has no effect.
- R5: Polarity bit 1 makes the active level high; polarity bit 0 makes it low. The inactive level is the complement.
- R6: A ratio write carrying 1 or a nonzero even value is accepted and restarts the frame at the write edge. A write carrying 0 or an odd value above 1 is ignored and leaves the phase and ratio unchanged.
- R7: While a realignment is armed, a ratio write is accepted only if the qualifier is high. When nothing is armed, the qualifier does not matter.
- R8: When a reference edge arrives while armed, the frame restarts at that edge (R2), the arming is used up, and the alarm is cleared.
- R9: A realignment is armed by a one-cycle realign request or by a rising edge on the lock input. The next reference edge then realigns the frame.
- R10: A reference edge sampled at edge E+m while nothing is armed does not move the phase. It sets the alarm to (m mod D) > 2^T, where T is the 3-bit threshold code, and the alarm holds that value until the next reference edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_ref | input | 1 | Sync reference; its rising edge marks the reference phase |
| realign_req | input | 1 | One-cycle request that arms a realignment |
| lock_in | input | 1 | Lock indication; a rising edge arms a realignment |
| cfg_div | input | DIV_W | Divide ratio to write |
| cfg_div_wr | input | 1 | Write strobe for the divide ratio |
| cfg_wr_qual | input | 1 | Write qualifier required while a realignment is armed |
| cfg_pol | input | 1 | Active level of the output |
| cfg_pw | input | PW_W | Pulse width in fast-clock cycles |
| cfg_half | input | 1 | Half-ratio width mode |
| cfg_thr | input | THR_W | Alarm threshold code T (limit 2^T cycles) |
| fs_out | output | 1 | Frame sync pulse |
| align_alarm | output | 1 | Alignment error alarm |

## Verification
The frame counter takes one edge to restart after an aligning event, and the output register takes one more edge. So the pulse level seen after edge E+m reflects frame position m-1, while the alarm reflects a reference edge sampled at E+m as soon as that edge has passed. The bench keeps its own count of rising edges. It drives stimulus and samples outputs only on falling edges, and it derives every expected level and alarm value from the edge number of the last aligning event using the formulas in R2 and R10. Phase checks cover at least two whole frames, so a wrong ratio, width or starting point shows up as a mismatch at a specific edge.

// File: rtl/fsg_pkg.sv
// Shared helpers for the frame sync generator.
// Assumes all inputs are passed zero-extended to 32 bits.
package fsg_pkg;

    // True for a divide ratio the generator accepts: 1 or a nonzero even value.
    function automatic logic div_is_legal(input logic [31:0] v);
        return (v == 32'd1) || ((v != 32'd0) && (v[0] == 1'b0));
    endfunction

    // Active cycles per frame for a given ratio, width field and half mode.
    function automatic logic [31:0] pulse_width(input logic [31:0] div,
                                                input logic [31:0] pw,
                                                input logic        half);
        if (half)
            return div >> 1;
        else if (pw >= div)
            return div - 32'd1;
        else
            return pw;
    endfunction

endpackage

// File: rtl/fsg_div_reg.sv
// Divide-ratio register. It rejects illegal ratios, and while a realignment
// is armed it requires the write qualifier. Assumes armed is a registered
// state from the phase counter.
module fsg_div_reg #(
    parameter int DIV_W   = 12,
    parameter int DIV_RST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] wr_data,
    input  logic             wr_en,
    input  logic             wr_qual,
    input  logic             armed,
    output logic [DIV_W-1:0] div_q,
    output logic             div_load
);
    import fsg_pkg::*;

    // Write acceptance: legal value, and gated by qualifier while armed.
    always_comb begin
        div_load = wr_en && div_is_legal(32'(wr_data)) && (!armed || wr_qual);
    end

    // Ratio storage with reset default.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= DIV_W'(DIV_RST);
        else if (div_load)
            div_q <= wr_data;
    end

    // R6: the stored ratio is always legal.
    p_div_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == DIV_W'(1)) || ((div_q != '0) && !div_q[0]));

    // R7: an unqualified write while armed leaves the ratio untouched.
    p_gated_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && armed && !wr_qual) |=> $stable(div_q));

endmodule

// File: rtl/fsg_phase_ctr.sv
// Frame phase counter with realignment arming and phase-error alarm.
// Assumes sync_ref and lock_in are already synchronous to clk. The error is
// the number of cycles from frame start to the reference edge, modulo div.
module fsg_phase_ctr #(
    parameter int DIV_W = 12,
    parameter int THR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_q,
    input  logic             div_load,
    input  logic             sync_ref,
    input  logic             realign_req,
    input  logic             lock_in,
    input  logic [THR_W-1:0] cfg_thr,
    output logic [DIV_W-1:0] cnt,
    output logic             armed,
    output logic             align_alarm
);
    logic             sync_d;
    logic             lock_d;
    logic             ref_rise;
    logic             lock_rise;
    logic             arm_now;
    logic             realign_fire;
    logic             last_phase;
    logic [DIV_W-1:0] phase_err;
    logic             err_over;

    // Edge detection, arming and error decode.
    always_comb begin
        ref_rise     = sync_ref && !sync_d;
        lock_rise    = lock_in && !lock_d;
        arm_now      = armed || realign_req || lock_rise;
        realign_fire = ref_rise && arm_now;
        last_phase   = (cnt == (div_q - DIV_W'(1)));
        phase_err    = last_phase ? '0 : (cnt + DIV_W'(1));
        err_over     = 32'(phase_err) > (32'(1) << cfg_thr);
    end

    // Input history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_d <= 1'b0;
            lock_d <= 1'b0;
        end else begin
            sync_d <= sync_ref;
            lock_d <= lock_in;
        end
    end

    // Realignment arming: set at reset, on request or lock rise; used by a reference edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b1;
        else if (realign_fire)
            armed <= 1'b0;
        else if (realign_req || lock_rise)
            armed <= 1'b1;
    end

    // Frame counter: restarts on realignment or ratio load, wraps at div-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (realign_fire || div_load || last_phase)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end

    // Alarm: cleared by realignment, refreshed on each unarmed reference edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            align_alarm <= 1'b0;
        else if (realign_fire)
            align_alarm <= 1'b0;
        else if (ref_rise)
            align_alarm <= err_over;
    end

    // R2: the counter always stays below the ratio.
    p_cnt_below_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < div_q);

    // R8: a realignment uses up the arming and clears the alarm.
    p_realign_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (realign_fire && !realign_req && !lock_rise) |=> (!armed && !align_alarm));

endmodule

// File: rtl/fsg_pulse_shaper.sv
// Turns the frame position into the registered pulse and applies polarity.
// Assumes cnt < div_q, which the phase counter guarantees.
module fsg_pulse_shaper #(
    parameter int DIV_W = 12,
    parameter int PW_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cnt,
    input  logic [DIV_W-1:0] div_q,
    input  logic [PW_W-1:0]  cfg_pw,
    input  logic             cfg_half,
    input  logic             cfg_pol,
    output logic             fs_out
);
    import fsg_pkg::*;

    logic [DIV_W-1:0] width_eff;
    logic             act_q;

    // Effective active width after clamp or half mode.
    always_comb begin
        width_eff = DIV_W'(pulse_width(32'(div_q), 32'(cfg_pw), cfg_half));
    end

    // Registered active flag for the frame position.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= 1'b0;
        else
            act_q <= (cnt < width_eff);
    end

    assign fs_out = act_q ? cfg_pol : !cfg_pol;

    // R3: a ratio of 1 never produces an active cycle.
    p_div1_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == DIV_W'(1)) |=> !act_q);

endmodule

// File: rtl/fsync_gen.sv
// Top level of the frame sync pulse generator: ratio register, phase counter
// with realignment and alarm, and pulse shaper. Single clock domain, all
// inputs synchronous to clk.
module fsync_gen #(
    parameter int DIV_W   = 12,
    parameter int PW_W    = 10,
    parameter int THR_W   = 3,
    parameter int DIV_RST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_ref,
    input  logic             realign_req,
    input  logic             lock_in,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_div_wr,
    input  logic             cfg_wr_qual,
    input  logic             cfg_pol,
    input  logic [PW_W-1:0]  cfg_pw,
    input  logic             cfg_half,
    input  logic [THR_W-1:0] cfg_thr,
    output logic             fs_out,
    output logic             align_alarm
);
    logic [DIV_W-1:0] div_q;
    logic             div_load;
    logic [DIV_W-1:0] cnt;
    logic             armed;

    fsg_div_reg #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (cfg_div),
        .wr_en    (cfg_div_wr),
        .wr_qual  (cfg_wr_qual),
        .armed    (armed),
        .div_q    (div_q),
        .div_load (div_load)
    );

    fsg_phase_ctr #(.DIV_W(DIV_W), .THR_W(THR_W)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_q       (div_q),
        .div_load    (div_load),
        .sync_ref    (sync_ref),
        .realign_req (realign_req),
        .lock_in     (lock_in),
        .cfg_thr     (cfg_thr),
        .cnt         (cnt),
        .armed       (armed),
        .align_alarm (align_alarm)
    );

    fsg_pulse_shaper #(.DIV_W(DIV_W), .PW_W(PW_W)) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .div_q    (div_q),
        .cfg_pw   (cfg_pw),
        .cfg_half (cfg_half),
        .cfg_pol  (cfg_pol),
        .fs_out   (fs_out)
    );

endmodule

// File: tb/fsync_gen_tb_top.sv
`timescale 1ns/1ps
module fsync_gen_tb_top;
    localparam int DIV_W = 12;
    localparam int PW_W  = 10;
    localparam int THR_W = 3;
    localparam int NV    = 6;

    // Stimulus table: ratio, width field, half mode, polarity, expected width.
    localparam int VDIV  [NV] = '{8, 10, 12, 6, 2, 16};
    localparam int VPW   [NV] = '{3, 20, 5, 2, 0, 16};
    localparam int VHALF [NV] = '{0, 0, 1, 0, 1, 0};
    localparam int VPOL  [NV] = '{1, 1, 1, 0, 0, 1};
    localparam int VW    [NV] = '{3, 9, 6, 2, 1, 15};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_ref = 1'b0;
    logic realign_req = 1'b0;
    logic lock_in = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic cfg_div_wr = 1'b0;
    logic cfg_wr_qual = 1'b0;
    logic cfg_pol = 1'b1;
    logic [PW_W-1:0] cfg_pw = '0;
    logic cfg_half = 1'b0;
    logic [THR_W-1:0] cfg_thr = '0;
    logic fs_out;
    logic align_alarm;

    int checks = 0;
    int errors = 0;
    int ecount = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) ecount <= ecount + 1;

    fsync_gen #(.DIV_W(DIV_W), .PW_W(PW_W), .THR_W(THR_W), .DIV_RST(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .sync_ref(sync_ref), .realign_req(realign_req),
        .lock_in(lock_in), .cfg_div(cfg_div), .cfg_div_wr(cfg_div_wr),
        .cfg_wr_qual(cfg_wr_qual), .cfg_pol(cfg_pol), .cfg_pw(cfg_pw),
        .cfg_half(cfg_half), .cfg_thr(cfg_thr), .fs_out(fs_out),
        .align_alarm(align_alarm)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Checks n consecutive levels against the frame formula relative to edge e.
    task automatic check_phase(input int e, input int d, input int w, input int pol,
                               input int n, input string tag);
        int bad = 0;
        int a_first = 0;
        int x_first = 0;
        for (int k = 0; k < n; k++) begin
            int m;
            int exp;
            @(negedge clk);
            m = ecount - e;
            exp = (((m - 1) % d) < w) ? pol : 1 - pol;
            if (int'(fs_out) != exp) begin
                if (bad == 0) begin
                    a_first = int'(fs_out);
                    x_first = exp;
                end
                bad++;
            end
        end
        chk(bad == 0, tag, a_first, x_first);
    endtask

    // Reference edge at the current falling edge; returns the sampling edge.
    task automatic do_sync(output int e);
        sync_ref = 1'b1;
        e = ecount + 1;
        @(negedge clk);
        sync_ref = 1'b0;
    endtask

    // Reference edge sampled at edge number tgt; ends where the alarm is visible.
    task automatic pulse_sync_at(input int tgt);
        while (ecount != tgt - 1) @(negedge clk);
        sync_ref = 1'b1;
        @(negedge clk);
        sync_ref = 1'b0;
    endtask

    task automatic write_div(input int v, input bit q, output int e);
        cfg_div = DIV_W'(v);
        cfg_wr_qual = q;
        cfg_div_wr = 1'b1;
        e = ecount + 1;
        @(negedge clk);
        cfg_div_wr = 1'b0;
        cfg_wr_qual = 1'b0;
    endtask

    task automatic pulse_req();
        realign_req = 1'b1;
        @(negedge clk);
        realign_req = 1'b0;
    endtask

    function automatic int next_frame(input int e, input int d, input int off);
        return e + d * (((ecount - e) / d) + 2) + off;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int e;
        int ew;
        int tg;
        cfg_pol = 1'b1;
        cfg_pw = PW_W'(2);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(fs_out == 1'b0, "R1 reset level", int'(fs_out), 0);
        chk(align_alarm == 1'b0, "R1 reset alarm", int'(align_alarm), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1: armed from reset, default ratio 8, no request needed
        do_sync(e);
        check_phase(e, 8, 2, 1, 20, "R1 first alignment");

        // Table walk: R2, R3, R4, R5
        for (int i = 0; i < NV; i++) begin
            string tag;
            cfg_pw = PW_W'(VPW[i]);
            cfg_half = VHALF[i][0];
            cfg_pol = VPOL[i][0];
            tag = (VHALF[i] != 0) ? "R4 half" : (VPW[i] >= VDIV[i]) ? "R3 clamp"
                  : (VPOL[i] == 0) ? "R5 low active" : "R2 frame";
            pulse_req();
            write_div(VDIV[i], 1'b1, ew);
            repeat (3) @(negedge clk);
            do_sync(e);
            check_phase(e, VDIV[i], VW[i], VPOL[i], 2 * VDIV[i] + 2, tag);
        end

        // R10: unarmed reference edges measure error, phase unmoved
        cfg_pw = PW_W'(4);
        cfg_half = 1'b0;
        cfg_pol = 1'b1;
        cfg_thr = 3'd1;
        tg = next_frame(e, 16, 0);
        pulse_sync_at(tg);
        chk(align_alarm == 1'b0, "R10 zero error", int'(align_alarm), 0);
        tg = next_frame(e, 16, 3);
        pulse_sync_at(tg);
        chk(align_alarm == 1'b1, "R10 error 3 over 2", int'(align_alarm), 1);
        check_phase(e, 16, 4, 1, 20, "R10 phase kept");
        cfg_thr = 3'd2;
        tg = next_frame(e, 16, 4);
        pulse_sync_at(tg);
        chk(align_alarm == 1'b0, "R10 error equal limit", int'(align_alarm), 0);
        tg = next_frame(e, 16, 5);
        pulse_sync_at(tg);
        chk(align_alarm == 1'b1, "R10 error 5 over 4", int'(align_alarm), 1);

        // R9: lock rise arms; R8: realignment clears alarm
        repeat (3) @(negedge clk);
        lock_in = 1'b1;
        repeat (2) @(negedge clk);
        do_sync(e);
        chk(align_alarm == 1'b0, "R8 alarm cleared", int'(align_alarm), 1'b0);
        check_phase(e, 16, 4, 1, 34, "R9 lock realign");

        // R7: unqualified write blocked while armed
        pulse_req();
        write_div(12, 1'b0, ew);
        repeat (2) @(negedge clk);
        do_sync(e);
        check_phase(e, 16, 4, 1, 34, "R7 blocked write");
        // R7: unarmed write accepted without qualifier, restarts frame (R6)
        write_div(12, 1'b0, e);
        check_phase(e, 12, 4, 1, 26, "R7 unarmed write");

        // R6: odd and zero ratios ignored
        write_div(7, 1'b0, ew);
        check_phase(e, 12, 4, 1, 26, "R6 odd ignored");
        write_div(0, 1'b0, ew);
        check_phase(e, 12, 4, 1, 26, "R6 zero ignored");

        // R3: ratio 1 never active
        write_div(1, 1'b0, e);
        check_phase(e, 1, 0, 1, 12, "R3 ratio one");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule